// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Master

This block is an 8-bit serial master for a synchronous link. A host loads bytes into a transmit holding register and takes bytes from a receive holding register. One shift register sits between the two and serves both directions. The block drives a shift clock, presents data on a serial output in NRZ form and samples a serial input, most-significant bit first. Each frame sends one byte and receives one byte at the same time. The shift clock comes from a divider on the system clock. It runs only while a frame is in progress.

Shifting starts and stops by itself. A single ready flag tracks the buffer that matters for the current direction. In transmit direction it tracks the transmit holding register, which must be full for a new frame to start. In receive direction it tracks the receive holding register. A byte that completes while the receive holding register is still full stays in the shift register, and the clock stops until the host frees the buffer. Received data is never overwritten. A mode bit selects the shift-clock edge on which the output changes. The input is always sampled on the other edge.

The host interface has a 2-bit address with a write strobe and a read strobe. Read data is registered and valid in the cycle after the read strobe. The address map is: 0 for data (a write loads the transmit holding register, a read takes the receive holding register), 1 for control, 2 for status (read-only) and 3 for the divider.

Top module: `sync_serial_master`

## Requirements
- R1: After reset, `sck`, `sd_out` and `irq` are 0. Control (address 1) reads 0x01, with bit0 = hold, bit1 = direction (1 = transmit), bit2 = edge mode and bit3 = interrupt enable. Status (address 2) reads 0x00, with bit0 = ready and bit1 = active. The divider (address 3) reads 0x00.
- R2: In transmit direction, a frame copies the transmit holding register into the shift register and sends its 8 bits most-significant bit first. `sd_out` changes only on launch edges of `sck`, or when the frame is loaded.
- R3: During the same frame, 8 input bits are sampled most-significant bit first. When the frame ends, the received byte is readable at address 0.
- R4: With edge mode 0, `sck` idles low, data changes on falling edges and input is sampled on rising edges. With edge mode 1, `sck` idles high, data changes on rising edges and input is sampled on falling edges. `sck` returns to its idle level after each frame.
- R5: Each half-period of `sck` lasts (divider + 1) system-clock cycles. The smallest divide of the system clock is therefore 2.
- R6: In transmit direction, status bit0 (ready) is 1 exactly while the transmit holding register is full. A frame starts only when the register is full, so with the register empty no frame starts and `sck` stays idle. A byte written during a frame is sent in the next frame.
- R7: In receive direction, ready is 1 while the receive holding register is empty. Clearing hold starts frames at once, and the block keeps receiving while a byte waits in the buffer. A frame that completes while the buffer is full stalls the clock, and the byte is held until the host reads address 0. Bytes are delivered in order with none lost.
- R8: Status bit1 (active) is 1 while a frame is being shifted and 0 between frames.
- R9: With interrupt enable set, `irq` pulses for one cycle each time the transmit holding register is consumed (transmit direction) or the receive holding register is filled (receive direction). With interrupt enable clear, it stays 0.
- R10: Setting hold stops a frame in progress, returns `sck` to idle, and clears both buffer-full flags and any held byte, so status reads 0x00. After hold is cleared again, no frame starts until new data is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Register write strobe |
| host_re | input | 1 | Register read strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data, valid the cycle after `host_re` |
| sck | output | 1 | Shift clock |
| sd_out | output | 1 | Serial data out, MSB first |
| sd_in | input | 1 | Serial data in |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench runs a table of bytes across both edge modes and several divider values. A slave model records `sd_out` on capture edges and shifts its own stream on launch edges. A design that samples on the launch edge, or shifts LSB first, returns the wrong byte. In receive direction the bench deliberately reads late. A design that overwrote the full buffer, or kept clocking, would show extra shift-clock edges or skip a byte in the sequence read back. The bench also sets hold in mid-frame and checks the interrupt count against the number of buffer events. This catches a block that kept shifting after hold, or that raised a second pulse.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;

  typedef struct packed {
    logic irq_en;
    logic edge_sel;
    logic dir_tx;
    logic hold;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{irq_en: 1'b0, edge_sel: 1'b0, dir_tx: 1'b0, hold: 1'b1};
endpackage

// File: rtl/ssm_baud.sv
module ssm_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  // >= keeps the counter bounded if the divider shrinks mid-frame
  assign tick = run && (cnt >= half_div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ssm_shifter.sv
module ssm_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enable,
  input  logic         start,
  input  logic [W-1:0] load_data,
  input  logic         edge_sel,
  input  logic         sd_in,
  input  logic         tick,
  output logic         sck,
  output logic         sd_out,
  output logic         act,
  output logic         done,
  output logic [W-1:0] shreg
);
  localparam int PH_W = $clog2(2 * W);
  localparam logic [PH_W-1:0] LAST = PH_W'(2 * W - 1);

  logic            cap;
  logic [PH_W-1:0] ph;

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      act    <= 1'b0;
      ph     <= '0;
      sck    <= 1'b0;
      sd_out <= 1'b0;
      shreg  <= '0;
      cap    <= 1'b0;
    end else if (!enable) begin
      act <= 1'b0;
      ph  <= '0;
      sck <= edge_sel;
    end else if (!act) begin
      sck <= edge_sel;
      if (start) begin
        act    <= 1'b1;
        ph     <= '0;
        shreg  <= load_data;
        sd_out <= load_data[W-1];
      end
    end else if (tick) begin
      ph <= ph + 1'b1;
      if (ph == LAST) begin
        sck   <= edge_sel;
        act   <= 1'b0;
        done  <= 1'b1;
        shreg <= {shreg[W-2:0], cap};
      end else begin
        sck <= ~sck;
        if (!ph[0]) begin
          cap <= sd_in;
        end else begin
          shreg  <= {shreg[W-2:0], cap};
          sd_out <= shreg[W-2];
        end
      end
    end
  end
endmodule

// File: rtl/ssm_host.sv
module ssm_host
  import ssm_pkg::*;
#(
  parameter int W     = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic             re,
  input  logic [1:0]       addr,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output ctrl_t            ctrl,
  output logic [DIV_W-1:0] half_div,
  input  logic             act,
  input  logic             done,
  input  logic [W-1:0]     shreg,
  output logic             start,
  output logic [W-1:0]     load_data,
  output logic             tx_full,
  output logic             pend,
  output logic             irq
);
  logic [W-1:0] tx_buf, rx_buf;
  logic         rx_full, ready, rd_rx, wr_tx;

  assign rd_rx     = re && (addr == A_DATA);
  assign wr_tx     = we && (addr == A_DATA);
  assign ready     = !ctrl.hold && (ctrl.dir_tx ? tx_full : !rx_full);
  assign start     = !ctrl.hold && !act && !done && !pend && (!ctrl.dir_tx || tx_full);
  assign load_data = tx_buf;

  always_ff @(posedge clk) begin
    irq <= 1'b0;
    if (rst) begin
      ctrl     <= CTRL_RST;
      half_div <= '0;
      tx_buf   <= '0;
      rx_buf   <= '0;
      tx_full  <= 1'b0;
      rx_full  <= 1'b0;
      pend     <= 1'b0;
      rdata    <= '0;
    end else begin
      if (re) begin
        case (addr)
          A_DATA:  rdata <= rx_buf;
          A_CTRL:  rdata <= W'(ctrl);
          A_STAT:  rdata <= W'({act, ready});
          default: rdata <= W'(half_div);
        endcase
      end
      if (we && addr == A_CTRL) ctrl     <= ctrl_t'(wdata[3:0]);
      if (we && addr == A_DIV)  half_div <= wdata[DIV_W-1:0];
      if (ctrl.hold) begin
        tx_full <= 1'b0;
        rx_full <= 1'b0;
        pend    <= 1'b0;
      end else begin
        if (start && ctrl.dir_tx) begin
          tx_full <= 1'b0;
          irq     <= ctrl.irq_en;
        end
        if (wr_tx) begin
          tx_buf  <= wdata;
          tx_full <= 1'b1;
        end
        if (rd_rx) rx_full <= 1'b0;
        if (done) begin
          if (ctrl.dir_tx || !rx_full || rd_rx) begin
            rx_buf  <= shreg;
            rx_full <= 1'b1;
            if (!ctrl.dir_tx) irq <= ctrl.irq_en;
          end else begin
            pend <= 1'b1;
          end
        end else if (pend && !rx_full) begin
          rx_buf  <= shreg;
          rx_full <= 1'b1;
          pend    <= 1'b0;
          irq     <= ctrl.irq_en;
        end
      end
    end
  end
endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
  import ssm_pkg::*;
#(
  parameter int W     = 8,
  parameter int DIV_W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         host_we,
  input  logic         host_re,
  input  logic [1:0]   host_addr,
  input  logic [W-1:0] host_wdata,
  output logic [W-1:0] host_rdata,
  output logic         sck,
  output logic         sd_out,
  input  logic         sd_in,
  output logic         irq
);
  ctrl_t            ctrl;
  logic [DIV_W-1:0] half_div;
  logic             act, done, start, tick, tx_full, pend;
  logic [W-1:0]     shreg, load_data;
  logic             cfg_hold, cfg_dir, cfg_edge;

  assign cfg_hold = ctrl.hold;
  assign cfg_dir  = ctrl.dir_tx;
  assign cfg_edge = ctrl.edge_sel;

  ssm_host #(.W(W), .DIV_W(DIV_W)) u_host (
    .clk(clk), .rst(rst), .we(host_we), .re(host_re), .addr(host_addr),
    .wdata(host_wdata), .rdata(host_rdata), .ctrl(ctrl), .half_div(half_div),
    .act(act), .done(done), .shreg(shreg), .start(start), .load_data(load_data),
    .tx_full(tx_full), .pend(pend), .irq(irq)
  );

  ssm_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst(rst), .run(act), .half_div(half_div), .tick(tick)
  );

  ssm_shifter #(.W(W)) u_shift (
    .clk(clk), .rst(rst), .enable(!cfg_hold), .start(start), .load_data(load_data),
    .edge_sel(cfg_edge), .sd_in(sd_in), .tick(tick), .sck(sck), .sd_out(sd_out),
    .act(act), .done(done), .shreg(shreg)
  );
endmodule

// File: rtl/ssm_checker.sv
module ssm_checker (
  input logic clk,
  input logic rst,
  input logic sck,
  input logic sd_out,
  input logic irq,
  input logic act,
  input logic hold,
  input logic dir_tx,
  input logic edge_sel,
  input logic tx_full,
  input logic pend
);
  a_r4_idle_level: assert property (@(posedge clk) disable iff (rst)
    (!act && $stable(edge_sel)) |-> (sck == edge_sel));

  a_r2_data_on_launch: assert property (@(posedge clk) disable iff (rst)
    ($past(act) && act && $stable(sck)) |-> $stable(sd_out));

  a_r6_start_needs_data: assert property (@(posedge clk) disable iff (rst)
    ($rose(act) && dir_tx) |-> $past(tx_full));

  a_r7_held_byte_stalls: assert property (@(posedge clk) disable iff (rst)
    pend |-> !act);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  a_r10_hold_stops: assert property (@(posedge clk) disable iff (rst)
    hold |=> !act);
endmodule

bind sync_serial_master ssm_checker u_chk (
  .clk(clk), .rst(rst), .sck(sck), .sd_out(sd_out), .irq(irq), .act(act),
  .hold(cfg_hold), .dir_tx(cfg_dir), .edge_sel(cfg_edge), .tx_full(tx_full), .pend(pend)
);

// File: tb/tb_sync_serial_master.sv
module tb_sync_serial_master;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] AD_DATA = 2'd0, AD_CTRL = 2'd1, AD_STAT = 2'd2, AD_DIV = 2'd3;
  // {edge, tx byte, slave byte, divider}
  localparam int NV = 6;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 8'h35, 8'hCA, 8'd0}, {1'b1, 8'h35, 8'h5C, 8'd1},
    {1'b0, 8'hA5, 8'h0F, 8'd2}, {1'b1, 8'h80, 8'h01, 8'd0},
    {1'b0, 8'hFF, 8'h00, 8'd3}, {1'b1, 8'h00, 8'hFF, 8'd1}};

  logic clk = 1'b0, rst = 1'b1;
  logic host_we = 1'b0, host_re = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_wdata = 8'h00, host_rdata;
  logic sck, sd_out, sd_in, irq;

  sync_serial_master dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .sck(sck), .sd_out(sd_out),
    .sd_in(sd_in), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_fail = 0, n_irq = 0, cyc = 0, cap_cnt = 0, gap = 1, last_gap = 0;
  logic tb_edge = 1'b0;
  logic [31:0] slv = 32'h0;
  logic [7:0] mst_bits = 8'h0;
  logic sck_d = 1'b0;

  assign sd_in = slv[31];

  // slave model: capture master output away from idle, shift own stream back to idle
  always @(sck) begin
    if (sck !== tb_edge) begin
      mst_bits = {mst_bits[6:0], sd_out};
      cap_cnt  = cap_cnt + 1;
    end else begin
      slv = slv << 1;
    end
  end

  always @(posedge clk) begin
    if (sck !== sck_d) begin
      last_gap <= gap;
      gap      <= 1;
    end else begin
      gap <= gap + 1;
    end
    sck_d <= sck;
    if (irq === 1'b1) n_irq <= n_irq + 1;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: got %0d cycles expected under 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (got !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    host_re = 1'b1; host_addr = a;
    @(negedge clk);
    host_re = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_caps(input int n);
    while (cap_cnt < n) @(negedge clk);
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    do rd(AD_STAT, s); while (s[1]);
  endtask

  initial begin
    logic [7:0] r;
    int c, n0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "sck", 32'(sck), 32'h0);
    chk("R1", "sd_out", 32'(sd_out), 32'h0);
    chk("R1", "irq", 32'(irq), 32'h0);
    rd(AD_CTRL, r); chk("R1", "control", 32'(r), 32'h01);
    rd(AD_STAT, r); chk("R1", "status", 32'(r), 32'h00);
    rd(AD_DIV, r);  chk("R1", "divider", 32'(r), 32'h00);

    // table: transmit direction, both edges, several dividers
    for (int i = 0; i < NV; i++) begin
      logic e;
      logic [7:0] txb, slb, hd;
      {e, txb, slb, hd} = VEC[i];
      tb_edge = e;
      wr(AD_CTRL, {4'b0, 1'b0, e, 1'b1, 1'b1});
      wr(AD_DIV, hd);
      wait_cyc(2);
      chk("R4", "idle level before frame", 32'(sck), 32'(e));
      slv = {slb, 24'h0}; mst_bits = 8'h0; cap_cnt = 0;
      wr(AD_CTRL, {4'b0, 1'b0, e, 1'b1, 1'b0});
      wr(AD_DATA, txb);
      wait_caps(8);
      wait_idle();
      chk("R2", "bits sent MSB first", 32'(mst_bits), 32'(txb));
      chk("R4", "capture edges per frame", 32'(cap_cnt), 32'd8);
      chk("R5", "half period", 32'(last_gap), 32'(hd) + 32'd1);
      rd(AD_DATA, r); chk("R3", "byte received", 32'(r), 32'(slb));
      chk("R4", "idle level after frame", 32'(sck), 32'(e));
    end

    // R6 / R8 / R9: transmit flow control and status
    tb_edge = 1'b0;
    wr(AD_CTRL, 8'h0B);
    wr(AD_DIV, 8'd0);
    wr(AD_CTRL, 8'h0A);
    wait_cyc(4);
    cap_cnt = 0; n0 = n_irq;
    rd(AD_STAT, r); chk("R6", "empty buffer not ready", 32'(r), 32'h00);
    wait_cyc(30);
    chk("R6", "no frame without data", 32'(cap_cnt), 32'd0);
    wr(AD_DATA, 8'h3C);
    wait_caps(8); wait_idle(); wait_cyc(50);
    chk("R6", "stall after single byte", 32'(cap_cnt), 32'd8);
    chk("R6", "sck idle while stalled", 32'(sck), 32'h0);
    chk("R9", "one pulse per consumed byte", 32'(n_irq - n0), 32'd1);
    rd(AD_STAT, r); chk("R8", "idle status", 32'(r), 32'h00);
    wr(AD_DIV, 8'd4);
    wr(AD_DATA, 8'h11);
    rd(AD_STAT, r); chk("R8", "active during frame", 32'(r), 32'h02);
    wr(AD_DATA, 8'h22);
    rd(AD_STAT, r); chk("R6", "second byte queued", 32'(r), 32'h03);
    wait_caps(24); wait_idle();
    chk("R6", "queued byte sent next", 32'(mst_bits), 32'h22);
    chk("R9", "pulse count after queue", 32'(n_irq - n0), 32'd3);
    wr(AD_CTRL, 8'h02);
    n0 = n_irq;
    wr(AD_DATA, 8'h44);
    wait_caps(32); wait_idle();
    chk("R9", "no pulse when disabled", 32'(n_irq - n0), 32'd0);

    // R10: hold mid-frame
    wr(AD_DIV, 8'd4);
    cap_cnt = 0;
    wr(AD_DATA, 8'h5A);
    wait_caps(3);
    wr(AD_CTRL, 8'h03);
    wait_cyc(3);
    chk("R10", "sck idle after hold", 32'(sck), 32'h0);
    c = cap_cnt;
    wait_cyc(100);
    chk("R10", "shifting stopped", 32'(cap_cnt), 32'(c));
    rd(AD_STAT, r); chk("R10", "status cleared", 32'(r), 32'h00);
    wr(AD_CTRL, 8'h02);
    wait_cyc(100);
    chk("R10", "no frame after release", 32'(cap_cnt), 32'(c));

    // R7: receive direction, late reads, held byte
    wr(AD_CTRL, 8'h09);
    wr(AD_DIV, 8'd0);
    wait_cyc(3);
    slv = 32'hA1B2C3D4; cap_cnt = 0; n0 = n_irq;
    wr(AD_CTRL, 8'h08);
    wait_cyc(200);
    chk("R7", "continues then stalls", 32'(cap_cnt), 32'd16);
    rd(AD_STAT, r); chk("R7", "full buffer not ready", 32'(r), 32'h00);
    chk("R9", "pulse on buffer fill", 32'(n_irq - n0), 32'd1);
    rd(AD_DATA, r); chk("R7", "first byte", 32'(r), 32'hA1);
    wait_cyc(100);
    chk("R7", "one more frame after read", 32'(cap_cnt), 32'd24);
    rd(AD_DATA, r); chk("R7", "held byte delivered", 32'(r), 32'hB2);
    wait_cyc(100);
    chk("R9", "pulses after releases", 32'(n_irq - n0), 32'd3);
    rd(AD_DATA, r); chk("R7", "third byte", 32'(r), 32'hC3);
    wait_cyc(100);
    chk("R7", "frames paced by reads", 32'(cap_cnt), 32'd40);
    rd(AD_DATA, r); chk("R7", "fourth byte", 32'(r), 32'hD4);

    summary();
    $finish;
  end
endmodule